// File: doc/BRIEF.md
# Oldest Exception Writeback Selector

Vector memory micro-operations write back on several parallel ports in the same cycle. Any of them may report an exception. This block looks only at the ports that are valid and carry an exception flag, and it picks the one that is earliest in program order. It then passes that port's reorder-buffer position, micro-op index and cause to the merge buffer through a registered output.

Each port has three age keys. The first is a reorder-buffer index. The second is a wrap bit for that circular index. The third is a micro-op index, which orders the pieces of one instruction. A flush input also carries a reorder-buffer position. In the cycle it is raised, it removes every candidate that is not strictly older than that point.

The block registers the candidates first. The pairwise comparison tree therefore works from flops, and the result lands in a second register. As a result, a selection made from the ports sampled at clock edge k appears on the outputs right after edge k+1.

Top module: `oldest_exc_pick`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, `out_valid` is 0.
- R2: A port is a candidate only when both `port_valid[i]` and `port_exc[i]` are 1. A port that is valid but does not flag an exception never wins, even if it is older. A port that flags an exception but is not valid is ignored.
- R3: When two candidates have the same reorder-buffer index and the same wrap bit, the one with the smaller micro-op index is older.
- R4: When the wrap bits of two candidates are equal and their reorder-buffer indices differ, the smaller index is older.
- R5: When the wrap bits of two candidates differ, the larger reorder-buffer index is older.
- R6: When two candidates have the same wrap bit, reorder-buffer index and micro-op index, the lower port number wins. `out_port` reports the winning port number.
- R7: Ports sampled at rising edge k produce the selection on the outputs after edge k+1. That selection lasts one cycle: `out_valid` falls again unless a new candidate was sampled at edge k+1.
- R8: When `flush_valid` is 1 in the cycle the ports are sampled, any candidate is dropped unless its reorder-buffer position is strictly older than (`flush_wrap`, `flush_idx`) under the rules of R4 and R5. Equal positions are dropped. If every candidate is dropped, `out_valid` stays 0.
- R9: When no port is a candidate at edge k, `out_valid` is 0 after edge k+1.
- R10: When `out_valid` is 1, the outputs `out_rob_wrap`, `out_rob_idx`, `out_uop` and `out_cause` equal the winning port's inputs. Port i occupies the field slice `[i*W +: W]` of each packed input, where W is that field's width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| port_valid | input | NPORT | Writeback valid per port |
| port_exc | input | NPORT | Exception flag per port |
| port_rob_wrap | input | NPORT | Wrap bit of the reorder-buffer index per port |
| port_rob_idx | input | NPORT*ROBW | Reorder-buffer index, port i at `[i*ROBW +: ROBW]` |
| port_uop | input | NPORT*UOPW | Micro-op index, port i at `[i*UOPW +: UOPW]` |
| port_cause | input | NPORT*CW | Exception cause, port i at `[i*CW +: CW]` |
| flush_valid | input | 1 | Flush request for this cycle |
| flush_wrap | input | 1 | Wrap bit of the flush point |
| flush_idx | input | ROBW | Reorder-buffer index of the flush point |
| out_valid | output | 1 | Selected record present |
| out_port | output | PW | Winning port number |
| out_rob_wrap | output | 1 | Winner's wrap bit |
| out_rob_idx | output | ROBW | Winner's reorder-buffer index |
| out_uop | output | UOPW | Winner's micro-op index |
| out_cause | output | CW | Winner's exception cause |

## Verification
The ordering assertions assume that no two live candidates are more than half the reorder-buffer range apart. Under that assumption, the wrap-bit rule gives a consistent age order. Every directed scenario places its indices well inside that window.

The idle and winner checks assume that reset is held for at least two edges, so both register stages start empty. The bench holds reset for several cycles before any stimulus. It also returns every input to zero between scenarios, so each scenario's result is seen in isolation.

// File: rtl/oldest_exc_pick.sv
module oldest_exc_pick #(
  parameter int NPORT = 3,
  parameter int ROBW  = 6,
  parameter int UOPW  = 7,
  parameter int CW    = 5,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int LVL  = (NPORT > 1) ? $clog2(NPORT) : 0,
  localparam int NPAD = 1 << LVL
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT-1:0]      port_valid,
  input  logic [NPORT-1:0]      port_exc,
  input  logic [NPORT-1:0]      port_rob_wrap,
  input  logic [NPORT*ROBW-1:0] port_rob_idx,
  input  logic [NPORT*UOPW-1:0] port_uop,
  input  logic [NPORT*CW-1:0]   port_cause,
  input  logic                  flush_valid,
  input  logic                  flush_wrap,
  input  logic [ROBW-1:0]       flush_idx,
  output logic                  out_valid,
  output logic [PW-1:0]         out_port,
  output logic                  out_rob_wrap,
  output logic [ROBW-1:0]       out_rob_idx,
  output logic [UOPW-1:0]       out_uop,
  output logic [CW-1:0]         out_cause
);

  function automatic logic rob_before(input logic [ROBW:0] a, input logic [ROBW:0] b);
    if (a[ROBW] == b[ROBW]) return a[ROBW-1:0] < b[ROBW-1:0];
    else                    return a[ROBW-1:0] > b[ROBW-1:0];
  endfunction

  function automatic logic is_older(input logic [ROBW:0] ar, input logic [UOPW-1:0] au,
                                    input logic [ROBW:0] br, input logic [UOPW-1:0] bu);
    if (ar == br) return au < bu;
    else          return rob_before(ar, br);
  endfunction

  logic [NPORT-1:0] s1_v;
  logic [ROBW:0]    s1_rob   [NPORT];
  logic [UOPW-1:0]  s1_uop   [NPORT];
  logic [CW-1:0]    s1_cause [NPORT];

  logic [ROBW:0] flush_pt;
  assign flush_pt = {flush_wrap, flush_idx};

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    logic [ROBW:0] rob_i;
    logic          keep_i;
    assign rob_i  = {port_rob_wrap[i], port_rob_idx[i*ROBW +: ROBW]};
    assign keep_i = !flush_valid || rob_before(rob_i, flush_pt);
    always_ff @(posedge clk) begin
      if (!rst_n) s1_v[i] <= 1'b0;
      else        s1_v[i] <= port_valid[i] && port_exc[i] && keep_i;
      s1_rob[i]   <= rob_i;
      s1_uop[i]   <= port_uop[i*UOPW +: UOPW];
      s1_cause[i] <= port_cause[i*CW +: CW];
    end
  end

  logic [1:2*NPAD-1] nv;
  logic [ROBW:0]     nrob   [1:2*NPAD-1];
  logic [UOPW-1:0]   nuop   [1:2*NPAD-1];
  logic [CW-1:0]     ncause [1:2*NPAD-1];
  logic [PW-1:0]     nport  [1:2*NPAD-1];

  for (genvar i = 0; i < NPAD; i++) begin : g_leaf
    if (i < NPORT) begin : g_real
      assign nv[NPAD+i]     = s1_v[i];
      assign nrob[NPAD+i]   = s1_rob[i];
      assign nuop[NPAD+i]   = s1_uop[i];
      assign ncause[NPAD+i] = s1_cause[i];
      assign nport[NPAD+i]  = PW'(i);
    end else begin : g_pad
      assign nv[NPAD+i]     = 1'b0;
      assign nrob[NPAD+i]   = '0;
      assign nuop[NPAD+i]   = '0;
      assign ncause[NPAD+i] = '0;
      assign nport[NPAD+i]  = '0;
    end
  end

  for (genvar k = 1; k < NPAD; k++) begin : g_node
    logic take_r;
    assign take_r = nv[2*k+1] &&
                    (!nv[2*k] || is_older(nrob[2*k+1], nuop[2*k+1], nrob[2*k], nuop[2*k]));
    assign nv[k]     = nv[2*k] || nv[2*k+1];
    assign nrob[k]   = take_r ? nrob[2*k+1]   : nrob[2*k];
    assign nuop[k]   = take_r ? nuop[2*k+1]   : nuop[2*k];
    assign ncause[k] = take_r ? ncause[2*k+1] : ncause[2*k];
    assign nport[k]  = take_r ? nport[2*k+1]  : nport[2*k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= nv[1];
    out_port                  <= nport[1];
    {out_rob_wrap, out_rob_idx} <= nrob[1];
    out_uop                   <= nuop[1];
    out_cause                 <= ncause[1];
  end

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(port_valid & port_exc)) |=> ##1 !out_valid);

  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(|s1_v));

  a_r2_winner_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> |($past(s1_v) & (NPORT'(1) << out_port)));

  always @(posedge clk) begin
    if (rst_n && nv[1]) begin
      for (int i = 0; i < NPORT; i++) begin
        a_r3_none_older: assert (!(s1_v[i] && is_older(s1_rob[i], s1_uop[i], nrob[1], nuop[1])));
      end
    end
  end

endmodule

// File: tb/oldest_exc_pick_test.sv
module oldest_exc_pick_test;
  localparam int NPORT = 3, ROBW = 6, UOPW = 7, CW = 5, PW = 2;

  logic clk = 0, rst_n = 0;
  logic [NPORT-1:0] pv = '0, pe = '0, pw = '0;
  logic [NPORT*ROBW-1:0] pidx = '0;
  logic [NPORT*UOPW-1:0] puop = '0;
  logic [NPORT*CW-1:0]   pcause = '0;
  logic fv = 0, fw = 0;
  logic [ROBW-1:0] fidx = '0;
  logic ov, owrap;
  logic [PW-1:0] oport;
  logic [ROBW-1:0] oidx;
  logic [UOPW-1:0] ouop;
  logic [CW-1:0] ocause;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  oldest_exc_pick #(.NPORT(NPORT), .ROBW(ROBW), .UOPW(UOPW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .port_valid(pv), .port_exc(pe), .port_rob_wrap(pw),
    .port_rob_idx(pidx), .port_uop(puop), .port_cause(pcause),
    .flush_valid(fv), .flush_wrap(fw), .flush_idx(fidx),
    .out_valid(ov), .out_port(oport), .out_rob_wrap(owrap), .out_rob_idx(oidx),
    .out_uop(ouop), .out_cause(ocause));

  task automatic clr();
    pv = '0; pe = '0; pw = '0; pidx = '0; puop = '0; pcause = '0;
    fv = 0; fw = 0; fidx = '0;
  endtask

  task automatic setp(int i, bit v, bit e, bit w, int idx, int uop, int cause);
    pv[i] = v; pe[i] = e; pw[i] = w;
    pidx[i*ROBW +: ROBW] = ROBW'(idx);
    puop[i*UOPW +: UOPW] = UOPW'(uop);
    pcause[i*CW +: CW]   = CW'(cause);
  endtask

  task automatic chk_none(string req);
    checks++;
    if (ov !== 1'b0) begin
      errors++;
      $display("FAIL %s: out_valid actual %0b expected 0", req, ov);
    end
  endtask

  task automatic chk_out(string req, int port, bit w, int idx, int uop, int cause);
    checks++;
    if (ov !== 1'b1 || oport !== PW'(port) || owrap !== w || oidx !== ROBW'(idx) ||
        ouop !== UOPW'(uop) || ocause !== CW'(cause)) begin
      errors++;
      $display("FAIL %s: actual v=%0b port=%0d w=%0b idx=%0d uop=%0d cause=%0d expected v=1 port=%0d w=%0b idx=%0d uop=%0d cause=%0d",
               req, ov, oport, owrap, oidx, ouop, ocause, port, w, idx, uop, cause);
    end
  endtask

  // stimulus was set before this call; sample edge k, result after edge k+1
  task automatic run_and_wait();
    @(negedge clk); clr();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_none("R1 during reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk_none("R1 after reset");
  endtask

  task automatic t_only_exc();
    setp(0, 1, 0, 0, 2, 0, 9);
    setp(1, 1, 1, 0, 10, 3, 17);
    setp(2, 0, 1, 0, 1, 0, 4);
    run_and_wait();
    chk_out("R2 non-excepting/invalid ignored", 1, 0, 10, 3, 17);
    @(negedge clk);
    chk_none("R7 one-cycle pulse");
  endtask

  task automatic t_same_rob();
    setp(0, 1, 1, 0, 5, 4, 1);
    setp(2, 1, 1, 0, 5, 1, 2);
    run_and_wait();
    chk_out("R3 lower uop older", 2, 0, 5, 1, 2);
    @(negedge clk);
  endtask

  task automatic t_same_wrap();
    setp(0, 1, 1, 0, 20, 0, 3);
    setp(1, 1, 1, 0, 7, 9, 5);
    setp(2, 1, 1, 0, 30, 0, 6);
    run_and_wait();
    chk_out("R4 smaller index older", 1, 0, 7, 9, 5);
    @(negedge clk);
  endtask

  task automatic t_diff_wrap();
    setp(0, 1, 1, 1, 3, 0, 11);
    setp(1, 1, 1, 0, 60, 2, 12);
    run_and_wait();
    chk_out("R5 larger index older across wrap", 1, 0, 60, 2, 12);
    @(negedge clk);
  endtask

  task automatic t_tie();
    setp(1, 1, 1, 1, 14, 6, 21);
    setp(2, 1, 1, 1, 14, 6, 22);
    run_and_wait();
    chk_out("R6 full tie lower port", 1, 1, 14, 6, 21);
    @(negedge clk);
  endtask

  task automatic t_flush();
    fv = 1; fw = 0; fidx = 8;
    setp(0, 1, 1, 0, 8, 0, 1);
    setp(1, 1, 1, 0, 9, 0, 2);
    setp(2, 1, 1, 0, 5, 3, 3);
    run_and_wait();
    chk_out("R8 flush keeps strictly older", 2, 0, 5, 3, 3);
    @(negedge clk);
    fv = 1; fw = 0; fidx = 8;
    setp(0, 1, 1, 0, 8, 0, 1);
    setp(1, 1, 1, 1, 2, 0, 2);
    run_and_wait();
    chk_none("R8 all candidates flushed");
    @(negedge clk);
  endtask

  task automatic t_idle();
    setp(0, 1, 0, 0, 1, 0, 1);
    setp(1, 1, 0, 0, 2, 0, 1);
    run_and_wait();
    chk_none("R9 no exception no output");
  endtask

  task automatic t_back_to_back();
    setp(0, 1, 1, 0, 12, 0, 7);
    @(negedge clk); clr();
    setp(2, 1, 1, 1, 40, 1, 8);
    @(negedge clk); clr();
    chk_out("R7 first of back-to-back", 0, 0, 12, 0, 7);
    @(negedge clk);
    chk_out("R10 second of back-to-back", 2, 1, 40, 1, 8);
    @(negedge clk);
    chk_none("R7 drops after last");
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    t_reset();
    t_only_exc();
    t_same_rob();
    t_same_wrap();
    t_diff_wrap();
    t_tie();
    t_flush();
    t_idle();
    t_back_to_back();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule